// File: doc/BRIEF.md
# Compressed-Row Sparse Matrix-Vector Engine

This processing element computes b = A·x for a sparse matrix A stored in compressed-row form. Three inputs feed it. A nonzero stream delivers one value and its column index per beat. A row-pointer stream delivers the offsets that divide the nonzero stream into rows. A write port fills a local vector memory with the entries of x. Each accepted nonzero is multiplied by the x entry that its column index selects. The engine emits one signed fixed-point dot product per row, tagged with the row number and delivered in row order on a valid/ready output.

The accumulator adder has a latency of `ADD_LAT` cycles, yet a product may arrive every cycle. The engine does not stall on each add. Running sums circulate through `ADD_LAT` interleaved slots of the adder ring, and each product is added to whichever slot is passing the input at that moment. When a row ends, a reduction pass runs for `ADD_LAT` cycles. It collects every slot into one result and clears each slot as it leaves. While that pass runs, products of the next row may already enter the cleared slots.

The first row-pointer word of a matrix is its start offset. Each later word is the running nonzero index at which the current row ends. A one-cycle end-of-matrix pulse, given while the engine is idle, makes the next pointer word a fresh start offset and restarts row numbering at 0.

Top module: `spmv_csr_engine`

## Requirements
- R1: While reset is held and after it is released, `res_valid` is 0, `ptr_ready` is 1, and `nz_ready` stays 0 until a start offset and a row end have both been accepted.
- R2: The result for a row equals the signed sum, over that row's nonzeros, of value × x[column], taken in `ACC_W` bits with two's-complement wrap.
- R3: x entries written through the write port are the operands fetched by column index, and a rewritten entry changes every later result that uses it.
- R4: Results leave in row order, and `res_row` counts 0, 1, 2, … one step per row.
- R5: A row whose end offset equals its start offset (no nonzeros) emits a result of 0.
- R6: Inside a row, nonzeros offered back to back are accepted on consecutive cycles, with no stall between them.
- R7: While `res_valid` is 1 and `res_ready` is 0, `res_valid`, `res_row` and `res_sum` hold unchanged.
- R8: Gaps in `nz_valid` or `ptr_valid`, and backpressure on `res_ready`, do not change any result.
- R9: After an end-of-matrix pulse, the next pointer word is taken as a new start offset (any value), and row numbering restarts at 0.
- R10: A row with exactly one nonzero emits that single product.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| xw_en | input | 1 | Write strobe for the x vector memory |
| xw_addr | input | COL_W | x memory write address |
| xw_data | input | VAL_W | Signed x entry to write |
| nz_valid | input | 1 | Nonzero beat offered |
| nz_ready | output | 1 | Engine accepts a nonzero this cycle |
| nz_val | input | VAL_W | Signed nonzero value |
| nz_col | input | COL_W | Column index of the nonzero |
| ptr_valid | input | 1 | Row-pointer word offered |
| ptr_ready | output | 1 | Engine accepts a row-pointer word this cycle |
| ptr_data | input | PTR_W | Start offset or row end offset |
| mat_last | input | 1 | End-of-matrix pulse, given while idle |
| res_valid | output | 1 | Row result available |
| res_ready | input | 1 | Consumer takes the result |
| res_row | output | ROW_W | Row number of the result |
| res_sum | output | ACC_W | Signed dot product of the row |

## Verification
A slot of the adder ring that is not cleared during a reduction pass shows up as a leftover term in the next row's result. That result appears about `ADD_LAT`+3 cycles after that row closes. A fault in the nonzero counter or the row-end compare moves products across a row boundary. It then shows as two neighbouring rows wrong by equal and opposite amounts, on the very next results. Empty rows, single-element rows and a nonzero start offset each probe a different part of the boundary logic. Random gaps and backpressure check that the handshakes never drop or repeat a beat.

// File: rtl/spmv_pkg.sv
package spmv_pkg;

    parameter int VAL_W = 16;
    parameter int COL_W = 6;
    parameter int PTR_W = 16;
    parameter int ROW_W = 10;
    parameter int ACC_W = 40;

    localparam int PROD_W  = 2 * VAL_W;
    localparam int X_DEPTH = 1 << COL_W;

    typedef logic signed [VAL_W-1:0]  val_t;
    typedef logic signed [PROD_W-1:0] prod_t;
    typedef logic signed [ACC_W-1:0]  acc_t;
    typedef logic [ROW_W-1:0]         row_t;
    typedef logic [PTR_W-1:0]         ptr_t;

    // beat leaving the row controller
    typedef struct packed {
        logic mark;     // row closes here
        logic nz_v;     // a nonzero was taken
        row_t row;
        val_t val;
    } issue_t;

    // beat entering the accumulator
    typedef struct packed {
        logic  mark;
        logic  prod_v;
        row_t  row;
        prod_t prod;
    } prod_beat_t;

    function automatic acc_t widen_prod(input prod_t p);
        return ACC_W'(p);
    endfunction

endpackage

// File: rtl/spmv_rowctl.sv
module spmv_rowctl
    import spmv_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   ptr_valid,
    output logic   ptr_ready,
    input  ptr_t   ptr_data,
    input  logic   nz_valid,
    output logic   nz_ready,
    input  val_t   nz_val,
    input  logic   mat_last,
    input  logic   busy,
    output issue_t issue
);

    logic have_base;
    logic end_v;
    ptr_t idx_q;
    ptr_t end_q;
    row_t row_q;
    logic at_end;
    logic close_fire;
    logic nz_fire;

    assign at_end     = end_v && (idx_q == end_q);
    assign ptr_ready  = !end_v;
    assign nz_ready   = end_v && !at_end;
    assign nz_fire    = nz_valid && nz_ready;
    assign close_fire = at_end && !busy;

    always_comb begin
        issue.mark = close_fire;
        issue.nz_v = nz_fire;
        issue.row  = row_q;
        issue.val  = nz_val;
    end

    always_ff @(posedge clk) begin
        if (rst || mat_last) begin
            have_base <= 1'b0;
            end_v     <= 1'b0;
            idx_q     <= '0;
            end_q     <= '0;
            row_q     <= '0;
        end else begin
            if (ptr_valid && ptr_ready) begin
                if (!have_base) begin
                    idx_q     <= ptr_data;
                    have_base <= 1'b1;
                end else begin
                    end_q <= ptr_data;
                    end_v <= 1'b1;
                end
            end
            if (nz_fire) idx_q <= idx_q + 1'b1;
            if (close_fire) begin
                end_v <= 1'b0;
                row_q <= row_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/spmv_mulstage.sv
module spmv_mulstage
    import spmv_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             xw_en,
    input  logic [COL_W-1:0] xw_addr,
    input  val_t             xw_data,
    input  issue_t           issue,
    input  logic [COL_W-1:0] nz_col,
    output prod_beat_t       beat,
    output logic             busy
);

    val_t   xmem [X_DEPTH];
    val_t   x_q;
    issue_t s1;
    prod_t  a_ext;
    prod_t  b_ext;

    always_ff @(posedge clk) begin
        if (xw_en) xmem[xw_addr] <= xw_data;
    end

    // stage 1: indirect x fetch by column index
    always_ff @(posedge clk) begin
        if (rst) begin
            s1  <= '0;
            x_q <= '0;
        end else begin
            s1 <= issue;
            if (issue.nz_v) x_q <= xmem[nz_col];
        end
    end

    assign a_ext = PROD_W'($signed(s1.val));
    assign b_ext = PROD_W'(x_q);

    // stage 2: product
    always_ff @(posedge clk) begin
        if (rst) begin
            beat <= '0;
        end else begin
            beat.mark   <= s1.mark;
            beat.prod_v <= s1.nz_v;
            beat.row    <= s1.row;
            beat.prod   <= a_ext * b_ext;
        end
    end

    assign busy = s1.mark || beat.mark;

    // R6
    mark_excl_chk: assert property (@(posedge clk) disable iff (rst)
        s1.mark |-> !s1.nz_v);

endmodule

// File: rtl/spmv_accum.sv
module spmv_accum
    import spmv_pkg::*;
#(
    parameter int ADD_LAT = 4
)(
    input  logic       clk,
    input  logic       rst,
    input  prod_beat_t beat,
    output logic       res_valid,
    input  logic       res_ready,
    output row_t       res_row,
    output acc_t       res_sum,
    output logic       busy
);

    localparam int CNT_W = $clog2(ADD_LAT + 1);

    acc_t             ring [ADD_LAT];
    acc_t             ring_out;
    acc_t             add_in;
    acc_t             red_acc;
    acc_t             red_sum;
    logic             drn_act;
    logic [CNT_W-1:0] drn_cnt;
    logic [CNT_W-1:0] cnt_eff;
    logic             drain_now;
    row_t             drn_row;

    assign ring_out  = ring[ADD_LAT-1];
    assign drain_now = beat.mark || drn_act;
    assign cnt_eff   = beat.mark ? '0 : drn_cnt;
    assign add_in    = (drain_now ? '0 : ring_out)
                     + (beat.prod_v ? widen_prod(beat.prod) : '0);
    assign red_sum   = ((cnt_eff == '0) ? '0 : red_acc) + ring_out;

    // adder ring: ADD_LAT interleaved partial sums
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < ADD_LAT; k++) ring[k] <= '0;
        end else begin
            ring[0] <= add_in;
            for (int k = 1; k < ADD_LAT; k++) ring[k] <= ring[k-1];
        end
    end

    // reduction pass and result register
    always_ff @(posedge clk) begin
        if (rst) begin
            drn_act   <= 1'b0;
            drn_cnt   <= '0;
            red_acc   <= '0;
            drn_row   <= '0;
            res_valid <= 1'b0;
            res_row   <= '0;
            res_sum   <= '0;
        end else begin
            if (res_valid && res_ready) res_valid <= 1'b0;
            if (beat.mark) drn_row <= beat.row;
            if (drain_now) begin
                red_acc <= red_sum;
                if (cnt_eff == CNT_W'(ADD_LAT - 1)) begin
                    drn_act   <= 1'b0;
                    res_valid <= 1'b1;
                    res_sum   <= red_sum;
                    res_row   <= beat.mark ? beat.row : drn_row;
                end else begin
                    drn_act <= 1'b1;
                    drn_cnt <= cnt_eff + 1'b1;
                end
            end
        end
    end

    assign busy = drn_act || res_valid;

    // R7
    res_hold_chk: assert property (@(posedge clk) disable iff (rst)
        res_valid && !res_ready |=> res_valid && $stable(res_sum) && $stable(res_row));

    // R4
    drain_excl_chk: assert property (@(posedge clk) disable iff (rst)
        beat.mark |-> !drn_act && !res_valid);

    // R4
    res_gap_chk: assert property (@(posedge clk) disable iff (rst)
        res_valid && res_ready |=> !res_valid);

    // R2
    res_source_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(res_valid) |-> $past(drain_now));

endmodule

// File: rtl/spmv_csr_engine.sv
module spmv_csr_engine
    import spmv_pkg::*;
#(
    parameter int ADD_LAT = 4
)(
    input  logic             clk,
    input  logic             rst,
    input  logic             xw_en,
    input  logic [COL_W-1:0] xw_addr,
    input  logic [VAL_W-1:0] xw_data,
    input  logic             nz_valid,
    output logic             nz_ready,
    input  logic [VAL_W-1:0] nz_val,
    input  logic [COL_W-1:0] nz_col,
    input  logic             ptr_valid,
    output logic             ptr_ready,
    input  logic [PTR_W-1:0] ptr_data,
    input  logic             mat_last,
    output logic             res_valid,
    input  logic             res_ready,
    output logic [ROW_W-1:0] res_row,
    output logic [ACC_W-1:0] res_sum
);

    issue_t     issue;
    prod_beat_t beat;
    logic       mul_busy;
    logic       acc_busy;
    acc_t       sum_s;

    spmv_rowctl u_ctl (
        .clk      (clk),
        .rst      (rst),
        .ptr_valid(ptr_valid),
        .ptr_ready(ptr_ready),
        .ptr_data (ptr_data),
        .nz_valid (nz_valid),
        .nz_ready (nz_ready),
        .nz_val   (val_t'(nz_val)),
        .mat_last (mat_last),
        .busy     (mul_busy || acc_busy),
        .issue    (issue)
    );

    spmv_mulstage u_mul (
        .clk    (clk),
        .rst    (rst),
        .xw_en  (xw_en),
        .xw_addr(xw_addr),
        .xw_data(val_t'(xw_data)),
        .issue  (issue),
        .nz_col (nz_col),
        .beat   (beat),
        .busy   (mul_busy)
    );

    spmv_accum #(.ADD_LAT(ADD_LAT)) u_acc (
        .clk      (clk),
        .rst      (rst),
        .beat     (beat),
        .res_valid(res_valid),
        .res_ready(res_ready),
        .res_row  (res_row),
        .res_sum  (sum_s),
        .busy     (acc_busy)
    );

    assign res_sum = sum_s;

    // R1
    nz_needs_end_chk: assert property (@(posedge clk) disable iff (rst)
        nz_valid && nz_ready |-> !ptr_ready);

endmodule

// File: tb/tb_spmv_csr_engine.sv
module tb_spmv_csr_engine;
    import spmv_pkg::*;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic             rst;
    logic             xw_en;
    logic [COL_W-1:0] xw_addr;
    logic [VAL_W-1:0] xw_data;
    logic             nz_valid;
    logic             nz_ready;
    logic [VAL_W-1:0] nz_val;
    logic [COL_W-1:0] nz_col;
    logic             ptr_valid;
    logic             ptr_ready;
    logic [PTR_W-1:0] ptr_data;
    logic             mat_last;
    logic             res_valid;
    logic             res_ready;
    logic [ROW_W-1:0] res_row;
    logic [ACC_W-1:0] res_sum;

    spmv_csr_engine #(.ADD_LAT(4)) dut (.*);

    // reference matrix: 5 rows, 13 nonzeros
    localparam int REF_PTR [6]  = '{0, 3, 5, 8, 11, 13};
    localparam int REF_VAL [13] = '{7, -3, 12, -25, 9, 4, 6, -4, -40, 27, 2, 8, -5};
    localparam int REF_COL [13] = '{0, 1, 3, 0, 1, 2, 3, 4, 0, 2, 3, 1, 4};
    // expected with x[k] = 2k - 5
    localparam int REF_EXP [5]  = '{-14, 98, -10, 175, -39};

    int  checks = 0;
    int  fails  = 0;
    bit  done   = 0;
    int  xm [X_DEPTH];
    int  m_ptr [0:64];
    int  m_val [0:511];
    int  m_col [0:511];
    longint m_exp [0:63];
    int  m_rows;
    int  gap_pct;
    int  bp_pct;
    int  nz_stalls;

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic load_x(input int mode);
        for (int k = 0; k < X_DEPTH; k++) begin
            xm[k] = (mode == 0) ? (2 * k - 5) : ((k * 7) % 23 - 11);
            @(negedge clk);
            xw_en   = 1'b1;
            xw_addr = COL_W'(k);
            xw_data = VAL_W'(xm[k]);
        end
        @(negedge clk);
        xw_en = 1'b0;
    endtask

    task automatic model_expect();
        for (int r = 0; r < m_rows; r++) begin
            m_exp[r] = 0;
            for (int k = m_ptr[r]; k < m_ptr[r+1]; k++)
                m_exp[r] += longint'(m_val[k - m_ptr[0]]) * longint'(xm[m_col[k - m_ptr[0]]]);
        end
    endtask

    task automatic drive_ptr();
        int r = 0;
        while (r <= m_rows) begin
            @(negedge clk);
            if (int'($urandom_range(99, 0)) < gap_pct) ptr_valid = 1'b0;
            else begin
                ptr_valid = 1'b1;
                ptr_data  = PTR_W'(m_ptr[r]);
            end
            #1;
            if (ptr_valid && ptr_ready) r++;
        end
        @(negedge clk);
        ptr_valid = 1'b0;
    endtask

    task automatic drive_nz();
        int j = 0;
        bit started = 0;
        int total = m_ptr[m_rows] - m_ptr[0];
        while (j < total) begin
            @(negedge clk);
            if (int'($urandom_range(99, 0)) < gap_pct) nz_valid = 1'b0;
            else begin
                nz_valid = 1'b1;
                nz_val   = VAL_W'(m_val[j]);
                nz_col   = COL_W'(m_col[j]);
            end
            #1;
            if (started && nz_valid && !nz_ready) nz_stalls++;
            if (nz_valid && nz_ready) begin
                j++;
                started = 1;
            end
        end
        @(negedge clk);
        nz_valid = 1'b0;
    endtask

    task automatic collect(input bit fresh);
        int r = 0;
        bit held = 0;
        logic [ACC_W-1:0] h_sum;
        logic [ROW_W-1:0] h_row;
        while (r < m_rows) begin
            @(negedge clk);
            res_ready = (int'($urandom_range(99, 0)) >= bp_pct);
            #1;
            if (held) begin
                // R7: held result unchanged under backpressure
                check(res_valid && res_sum == h_sum && res_row == h_row, "R7",
                      longint'($signed(res_sum)), longint'($signed(h_sum)));
            end
            held = res_valid && !res_ready;
            h_sum = res_sum;
            h_row = res_row;
            if (res_valid && res_ready) begin
                int len = m_ptr[r+1] - m_ptr[r];
                if (r == 0 && fresh)
                    check(res_row == 0, "R9", longint'(res_row), 0);
                check(res_row == ROW_W'(r), "R4", longint'(res_row), longint'(r));
                if (len == 0)
                    check($signed(res_sum) == 0, "R5", longint'($signed(res_sum)), 0);
                else if (len == 1)
                    check(longint'($signed(res_sum)) == m_exp[r], "R10",
                          longint'($signed(res_sum)), m_exp[r]);
                else
                    check(longint'($signed(res_sum)) == m_exp[r], "R2",
                          longint'($signed(res_sum)), m_exp[r]);
                r++;
            end
        end
        @(negedge clk);
        res_ready = 1'b0;
    endtask

    task automatic run(input bit fresh);
        fork
            drive_ptr();
            drive_nz();
            collect(fresh);
        join
        @(negedge clk);
        mat_last = 1'b1;
        @(negedge clk);
        mat_last = 1'b0;
    endtask

    task automatic gen_random(input int rows, input int base);
        int n = 0;
        m_rows   = rows;
        m_ptr[0] = base;
        for (int r = 0; r < rows; r++) begin
            int sel = int'($urandom_range(3, 0));
            int len = (sel == 0) ? 0 : (sel == 1) ? 1 : int'($urandom_range(11, 2));
            for (int k = 0; k < len; k++) begin
                m_val[n] = int'($urandom_range(600, 0)) - 300;
                m_col[n] = int'($urandom_range(X_DEPTH - 1, 0));
                n++;
            end
            m_ptr[r+1] = base + n;
        end
        model_expect();
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            summary();
            $finish;
        end
    end

    initial begin
        rst = 1'b1; xw_en = 0; xw_addr = '0; xw_data = '0;
        nz_valid = 0; nz_val = '0; nz_col = '0;
        ptr_valid = 0; ptr_data = '0; mat_last = 0; res_ready = 0;
        gap_pct = 0; bp_pct = 0; nz_stalls = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        #1;
        // R1: reset state
        check(res_valid == 1'b0, "R1", longint'(res_valid), 0);
        check(ptr_ready == 1'b1, "R1", longint'(ptr_ready), 1);
        check(nz_ready == 1'b0, "R1", longint'(nz_ready), 0);

        // table walk: reference matrix, R2 and R3 with x[k] = 2k - 5
        load_x(0);
        m_rows = 5;
        for (int k = 0; k < 13; k++) begin
            m_val[k] = REF_VAL[k];
            m_col[k] = REF_COL[k];
            if (k < 6) m_ptr[k] = REF_PTR[k];
            if (k < 5) m_exp[k] = longint'(REF_EXP[k]);
        end
        run(1'b0);

        // R3: rewritten x changes results; R8: gaps and backpressure
        load_x(1);
        model_expect();
        gap_pct = 30; bp_pct = 40;
        run(1'b1);

        // R5 / R9 / R10: empty and single rows, nonzero start offset
        m_rows = 6;
        m_ptr[0] = 100; m_ptr[1] = 100; m_ptr[2] = 101; m_ptr[3] = 101;
        m_ptr[4] = 104; m_ptr[5] = 105; m_ptr[6] = 105;
        m_val[0] = -300; m_col[0] = 63;
        m_val[1] = 11;   m_col[1] = 5;
        m_val[2] = 0;    m_col[2] = 9;
        m_val[3] = -7;   m_col[3] = 5;
        m_val[4] = 250;  m_col[4] = 0;
        model_expect();
        gap_pct = 20; bp_pct = 50;
        run(1'b1);

        // random matrices, R2 / R8
        for (int t = 0; t < 6; t++) begin
            gen_random(int'($urandom_range(24, 4)), int'($urandom_range(200, 0)));
            gap_pct = (t % 2) * 25;
            bp_pct  = (t % 3) * 30;
            run(1'b1);
        end

        // R6: one long row offered back to back, no stall
        m_rows = 1; m_ptr[0] = 0; m_ptr[1] = 20;
        for (int k = 0; k < 20; k++) begin
            m_val[k] = k * 13 - 100;
            m_col[k] = (k * 5) % X_DEPTH;
        end
        model_expect();
        gap_pct = 0; bp_pct = 0; nz_stalls = 0;
        run(1'b1);
        check(nz_stalls == 0, "R6", longint'(nz_stalls), 0);

        done = 1;
        summary();
        $finish;
    end

endmodule